// File: doc/BRIEF.md
# UART FIFO DMA Ready Controller

This block holds the transmit and receive character queues of one UART channel. It also produces the handshake and interrupt signals that a DMA engine or host uses to move data through those queues. The host programs it through a single 8-bit control write. That write selects whether the queues are active, fires one-shot queue flushes, and chooses the DMA signalling style and the fill thresholds.

Data moves in four streams. The host sends characters into the transmit queue, and the serial shifter takes them out. The serial shifter delivers received characters into the receive queue, and the host takes them out. Each stream except the receive input uses valid/ready. A transfer happens on a clock edge where both valid and ready are high. Ready on a queue input is low while that queue is at capacity. The receive input has no ready, because the line cannot be stalled. A received character that arrives while the queue is full is lost, and the loss is recorded.

The active-low ready pins and the interrupt requests are decoded from the stored occupancy counts and the stored control fields. They therefore reflect a push, a pop or a control write from the cycle right after the edge that performed it.

Top module: `uart_dma_ready_ctrl`

## Requirements
- R1: After reset both queues are empty, the control byte reads 0x00 (queues off, mode 0), txrdy_n=0, rxrdy_n=1, tx_irq=1, rx_irq=0, rx_overrun=0.
- R2: A control write stores bit 0 as queue enable, bit 3 as DMA block mode, bits 5:4 as transmit threshold select and bits 7:6 as receive threshold select. cfg_rdata returns these fields at the same positions, and bits 2:1 always read 0.
- R3: With queues enabled each queue holds 64 characters in first-in first-out order. tx_in_ready is low at 64, and a transmit offer made while full leaves the count at 64.
- R4: With queues disabled each direction holds at most one character, so its count is 0 or 1.
- R5: A receive character that arrives while the receive queue is at capacity is dropped and sets rx_overrun. The flag stays set until a receive flush (bit 1, or an enable change) or reset.
- R6: Writing 1 to bit 1 empties the receive queue, and writing 1 to bit 2 empties the transmit queue, by the next cycle. A flush wins over a push in the same cycle.
- R7: A control write that changes bit 0 empties both queues.
- R8: In mode 0, or with queues disabled, txrdy_n is low exactly when the transmit count is 0.
- R9: In mode 0, or with queues disabled, rxrdy_n is low exactly when the receive count is at least 1.
- R10: In block mode with queues enabled, txrdy_n is low exactly when the transmit count is below 64.
- R11: In block mode with queues enabled, rxrdy_n is low exactly when the receive count is at or above the receive threshold.
- R12: rx_irq is high when the receive count is at least the threshold. With queues enabled, select codes 0,1,2,3 give 8,16,56,60. With queues disabled the threshold is 1.
- R13: tx_irq is high when the transmit count is below the threshold. With queues enabled, select codes 0,1,2,3 give 8,16,32,56. With queues disabled the threshold is 1, so tx_irq is high when the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write value |
| cfg_rdata | output | 8 | Stored control fields, flush bits read 0 |
| tx_in_valid | input | 1 | Host offers a character for transmit |
| tx_in_ready | output | 1 | Transmit queue can accept |
| tx_in_data | input | 8 | Transmit character from host |
| tx_out_valid | output | 1 | Transmit queue has a character |
| tx_out_ready | input | 1 | Shifter takes the head character |
| tx_out_data | output | 8 | Head of transmit queue |
| rx_in_valid | input | 1 | Shifter delivers a received character |
| rx_in_data | input | 8 | Received character |
| rx_out_valid | output | 1 | Receive queue has a character |
| rx_out_ready | input | 1 | Host takes the head character |
| rx_out_data | output | 8 | Head of receive queue |
| tx_count | output | 7 | Transmit occupancy |
| rx_count | output | 7 | Receive occupancy |
| txrdy_n | output | 1 | Active-low transmit DMA request |
| rxrdy_n | output | 1 | Active-low receive DMA request |
| tx_irq | output | 1 | Transmit threshold interrupt request |
| rx_irq | output | 1 | Receive threshold interrupt request |
| rx_overrun | output | 1 | Sticky receive loss flag |

## Verification
The hardest states to reach are the upper thresholds and the full boundary. These are a receive count of exactly 56, 59 or 60 and a transmit count pinned at 64 while further offers arrive. Reaching them takes long runs of back-to-back pushes with the queue flushed at the start of each run. The stimulus table therefore pairs every control byte with exact push counts for each direction. Each run begins with a control write that also sets both flush bits. Directed cases then place a flush and a push on the same edge, and toggle the enable bit with data held, to cover the priority rules.

// File: rtl/uart_dq_pkg.sv
package uart_dq_pkg;

  localparam int CTL_ON   = 0;
  localparam int CTL_FRX  = 1;
  localparam int CTL_FTX  = 2;
  localparam int CTL_BLK  = 3;

  typedef struct packed {
    logic [1:0] rx_sel;
    logic [1:0] tx_sel;
    logic       blk_mode;
    logic       q_on;
  } dq_cfg_t;

  function automatic int unsigned rx_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 56;
      default: return 60;
    endcase
  endfunction

  function automatic int unsigned tx_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 16;
      2'd2:    return 32;
      default: return 56;
    endcase
  endfunction

endpackage

// File: rtl/uart_dq_fifo.sv
module uart_dq_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          one_slot,
  input  logic          push_valid,
  input  logic [W-1:0]  push_data,
  output logic          push_ready,
  output logic          push_drop,
  output logic          pop_valid,
  input  logic          pop_ready,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] count
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cap;
  logic          full, push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cap        = one_slot ? CW'(1) : CW'(DEPTH);
  assign full       = (count >= cap);
  assign push_ready = !full;
  assign push_ok    = push_valid && !full && !flush;
  assign push_drop  = push_valid && full && !flush;
  assign pop_valid  = (count != '0);
  assign pop_ok     = pop_ready && pop_valid && !flush;
  assign pop_data   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= nxt(wr_ptr);
      if (pop_ok)  rd_ptr <= nxt(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/uart_dq_cfg.sv
module uart_dq_cfg
  import uart_dq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output dq_cfg_t    cfg,
  output logic       flush_rx,
  output logic       flush_tx,
  output logic [7:0] rdata
);

  logic toggle;

  assign toggle   = we && (wdata[CTL_ON] != cfg.q_on);
  assign flush_rx = (we && wdata[CTL_FRX]) || toggle;
  assign flush_tx = (we && wdata[CTL_FTX]) || toggle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      cfg.rx_sel   <= wdata[7:6];
      cfg.tx_sel   <= wdata[5:4];
      cfg.blk_mode <= wdata[CTL_BLK];
      cfg.q_on     <= wdata[CTL_ON];
    end
  end

  assign rdata = {cfg.rx_sel, cfg.tx_sel, cfg.blk_mode, 2'b00, cfg.q_on};

endmodule

// File: rtl/uart_dq_ready.sv
module uart_dq_ready
  import uart_dq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  dq_cfg_t       cfg,
  input  logic [CW-1:0] tx_count,
  input  logic [CW-1:0] rx_count,
  output logic          txrdy_n,
  output logic          rxrdy_n,
  output logic          tx_irq,
  output logic          rx_irq
);

  logic [CW:0] rx_thr, tx_thr;
  logic        blk, rx_hit, tx_low;

  assign blk    = cfg.q_on && cfg.blk_mode;
  assign rx_thr = cfg.q_on ? (CW+1)'(rx_level(cfg.rx_sel)) : (CW+1)'(1);
  assign tx_thr = cfg.q_on ? (CW+1)'(tx_level(cfg.tx_sel)) : (CW+1)'(1);
  assign rx_hit = ({1'b0, rx_count} >= rx_thr);
  assign tx_low = ({1'b0, tx_count} <  tx_thr);

  always_comb begin
    if (blk) begin
      txrdy_n = (tx_count >= CW'(DEPTH));
      rxrdy_n = !rx_hit;
    end else begin
      txrdy_n = (tx_count != '0);
      rxrdy_n = (rx_count == '0);
    end
  end

  assign rx_irq = rx_hit;
  assign tx_irq = tx_low;

endmodule

// File: rtl/uart_dma_ready_ctrl.sv
module uart_dma_ready_ctrl
  import uart_dq_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [7:0]                 cfg_wdata,
  output logic [7:0]                 cfg_rdata,
  input  logic                       tx_in_valid,
  output logic                       tx_in_ready,
  input  logic [W-1:0]               tx_in_data,
  output logic                       tx_out_valid,
  input  logic                       tx_out_ready,
  output logic [W-1:0]               tx_out_data,
  input  logic                       rx_in_valid,
  input  logic [W-1:0]               rx_in_data,
  output logic                       rx_out_valid,
  input  logic                       rx_out_ready,
  output logic [W-1:0]               rx_out_data,
  output logic [$clog2(DEPTH+1)-1:0] tx_count,
  output logic [$clog2(DEPTH+1)-1:0] rx_count,
  output logic                       txrdy_n,
  output logic                       rxrdy_n,
  output logic                       tx_irq,
  output logic                       rx_irq,
  output logic                       rx_overrun
);

  localparam int CW = $clog2(DEPTH + 1);

  dq_cfg_t cfg;
  logic    flush_rx, flush_tx, rx_drop, tx_drop, rx_in_ready;

  uart_dq_cfg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .cfg      (cfg),
    .flush_rx (flush_rx),
    .flush_tx (flush_tx),
    .rdata    (cfg_rdata)
  );

  uart_dq_fifo #(.DEPTH(DEPTH), .W(W), .CW(CW)) u_txq (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush_tx),
    .one_slot   (!cfg.q_on),
    .push_valid (tx_in_valid),
    .push_data  (tx_in_data),
    .push_ready (tx_in_ready),
    .push_drop  (tx_drop),
    .pop_valid  (tx_out_valid),
    .pop_ready  (tx_out_ready),
    .pop_data   (tx_out_data),
    .count      (tx_count)
  );

  uart_dq_fifo #(.DEPTH(DEPTH), .W(W), .CW(CW)) u_rxq (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush_rx),
    .one_slot   (!cfg.q_on),
    .push_valid (rx_in_valid),
    .push_data  (rx_in_data),
    .push_ready (rx_in_ready),
    .push_drop  (rx_drop),
    .pop_valid  (rx_out_valid),
    .pop_ready  (rx_out_ready),
    .pop_data   (rx_out_data),
    .count      (rx_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rx_overrun <= 1'b0;
    else if (flush_rx) rx_overrun <= 1'b0;
    else if (rx_drop)  rx_overrun <= 1'b1;
  end

  uart_dq_ready #(.DEPTH(DEPTH), .CW(CW)) u_rdy (
    .cfg      (cfg),
    .tx_count (tx_count),
    .rx_count (rx_count),
    .txrdy_n  (txrdy_n),
    .rxrdy_n  (rxrdy_n),
    .tx_irq   (tx_irq),
    .rx_irq   (rx_irq)
  );

  logic unused_ok;
  assign unused_ok = &{1'b0, rx_in_ready, tx_drop};

endmodule

// File: rtl/uart_dq_chk.sv
module uart_dq_chk #(
  parameter int DEPTH = 64,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [7:0]    cfg_wdata,
  input logic [7:0]    cfg_rdata,
  input logic          rx_in_valid,
  input logic [CW-1:0] tx_count,
  input logic [CW-1:0] rx_count,
  input logic          rx_overrun
);

  logic          rx_flush_req;
  logic [CW-1:0] rx_cap;

  assign rx_flush_req = cfg_we && (cfg_wdata[1] || (cfg_wdata[0] != cfg_rdata[0]));
  assign rx_cap       = cfg_rdata[0] ? CW'(DEPTH) : CW'(1);

  a_r3_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CW'(DEPTH));

  a_r4_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[0] |-> (rx_count <= CW'(1)) && (tx_count <= CW'(1)));

  a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    rx_in_valid && (rx_count == rx_cap) && !rx_flush_req |=> rx_overrun);

  a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun && !rx_flush_req |=> rx_overrun);

  a_r6_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[1] |=> rx_count == '0);

  a_r6_tx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[2] |=> tx_count == '0);

endmodule

bind uart_dma_ready_ctrl uart_dq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_wdata   (cfg_wdata),
  .cfg_rdata   (cfg_rdata),
  .rx_in_valid (rx_in_valid),
  .tx_count    (tx_count),
  .rx_count    (rx_count),
  .rx_overrun  (rx_overrun)
);

// File: tb/tb_uart_dma_ready_ctrl.sv
module tb_uart_dma_ready_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       tx_in_valid = 1'b0, tx_in_ready, tx_out_valid, tx_out_ready = 1'b0;
  logic [7:0] tx_in_data = '0, tx_out_data;
  logic       rx_in_valid = 1'b0, rx_out_valid, rx_out_ready = 1'b0;
  logic [7:0] rx_in_data = '0, rx_out_data;
  logic [6:0] tx_count, rx_count;
  logic       txrdy_n, rxrdy_n, tx_irq, rx_irq, rx_overrun;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_dma_ready_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data),
    .tx_count(tx_count), .rx_count(rx_count), .txrdy_n(txrdy_n), .rxrdy_n(rxrdy_n),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .rx_overrun(rx_overrun)
  );

  // {control byte, rx pushes, tx pushes, expected {txrdy_n, rxrdy_n, tx_irq, rx_irq}}
  localparam logic [27:0] VEC [13] = '{
    {8'h00, 8'd0,  8'd0,  4'b0110},
    {8'h00, 8'd3,  8'd3,  4'b1001},
    {8'h01, 8'd7,  8'd7,  4'b1010},
    {8'h01, 8'd8,  8'd8,  4'b1001},
    {8'h09, 8'd7,  8'd7,  4'b0110},
    {8'h09, 8'd8,  8'd8,  4'b0001},
    {8'h59, 8'd15, 8'd15, 4'b0110},
    {8'hA9, 8'd56, 8'd31, 4'b0011},
    {8'hF9, 8'd59, 8'd56, 4'b0100},
    {8'hF9, 8'd64, 8'd70, 4'b1001},
    {8'hF1, 8'd0,  8'd0,  4'b0110},
    {8'h08, 8'd1,  8'd1,  4'b1001},
    {8'h51, 8'd16, 8'd15, 4'b1011}
  };

  task automatic chk(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pushes(input int nrx, input int ntx, input logic [7:0] base);
    int m;
    m = (nrx > ntx) ? nrx : ntx;
    for (int i = 0; i < m; i++) begin
      rx_in_valid = (i < nrx); rx_in_data = base + 8'(i);
      tx_in_valid = (i < ntx); tx_in_data = base + 8'(i);
      @(negedge clk);
    end
    rx_in_valid = 1'b0; tx_in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: got 0 expected 1");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cfg_rdata", cfg_rdata, 0);
    chk("R1 tx_count", tx_count, 0);
    chk("R1 rx_count", rx_count, 0);
    chk("R1 txrdy_n", txrdy_n, 0);
    chk("R1 rxrdy_n", rxrdy_n, 1);
    chk("R1 tx_irq", tx_irq, 1);
    chk("R1 rx_irq", rx_irq, 0);
    chk("R1 rx_overrun", rx_overrun, 0);

    // table walk: R8 to R13, counts for R3 and R4
    foreach (VEC[k]) begin
      logic [7:0] c;
      int nrx, ntx, cap;
      logic [3:0] e;
      c = VEC[k][27:20]; nrx = VEC[k][19:12]; ntx = VEC[k][11:4]; e = VEC[k][3:0];
      cap = c[0] ? 64 : 1;
      wr_cfg(c | 8'h06);
      pushes(nrx, ntx, 8'(k * 16));
      chk("R3/R4 rx_count", rx_count, (nrx < cap) ? nrx : cap);
      chk("R3/R4 tx_count", tx_count, (ntx < cap) ? ntx : cap);
      chk("R8/R10 txrdy_n", txrdy_n, e[3]);
      chk("R9/R11 rxrdy_n", rxrdy_n, e[2]);
      chk("R13 tx_irq", tx_irq, e[1]);
      chk("R12 rx_irq", rx_irq, e[0]);
      chk("R5 rx_overrun", rx_overrun, nrx > cap);
      if (c[0] && ntx >= 64) chk("R3 tx_in_ready full", tx_in_ready, 0);
    end

    // R2 field readback, flush bits read as zero
    wr_cfg(8'hFF);
    chk("R2 readback", cfg_rdata, 8'hF9);
    wr_cfg(8'h36);
    chk("R2 readback", cfg_rdata, 8'h30);

    // R3 order through both queues; R9 rxrdy_n returns high after draining
    wr_cfg(8'h07);
    pushes(3, 3, 8'h40);
    for (int i = 0; i < 3; i++) begin
      chk("R3 tx order", tx_out_data, 8'h40 + i);
      chk("R3 rx order", rx_out_data, 8'h40 + i);
      tx_out_ready = 1'b1; rx_out_ready = 1'b1;
      @(negedge clk);
      tx_out_ready = 1'b0; rx_out_ready = 1'b0;
    end
    chk("R9 rxrdy_n drained", rxrdy_n, 1);
    chk("R8 txrdy_n drained", txrdy_n, 0);

    // R5 sticky overrun in single-holding mode
    wr_cfg(8'h06);
    pushes(2, 0, 8'h55);
    chk("R5 overrun set", rx_overrun, 1);
    chk("R5 dropped keeps first", rx_out_data, 8'h55);
    wr_cfg(8'h00);
    chk("R5 overrun kept", rx_overrun, 1);
    wr_cfg(8'h02);
    chk("R5 overrun cleared", rx_overrun, 0);

    // R6 flush wins over a same-edge push
    wr_cfg(8'h01);
    pushes(5, 5, 8'h10);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 8'h03; rx_in_valid = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; rx_in_valid = 1'b0;
    chk("R6 rx flush", rx_count, 0);
    chk("R6 tx untouched", tx_count, 5);
    wr_cfg(8'h05);
    chk("R6 tx flush", tx_count, 0);

    // R7 enable change empties both queues
    pushes(4, 6, 8'h20);
    wr_cfg(8'h00);
    chk("R7 tx emptied", tx_count, 0);
    chk("R7 rx emptied", rx_count, 0);

    done = 1;
    finish_run();
  end

endmodule